// File: doc/BRIEF.md
# Programmable Strobe Width Wait-State Generator

This block drives the read or write strobe of an external peripheral bus access and holds the host bus cycle open while the strobe is active. A host-side bus interface pulses a start request together with a direction. The block then asserts exactly one active-low strobe for a programmed minimum pulse width. For as long as the strobe is low it raises a wait output, which the host interface turns into extra sync fields. When the strobe ends, the block raises a one-cycle done indication and returns to idle.

The pulse width comes from a 2-bit code held in a small selection register. The four codes give 180 ns, 300 ns, 420 ns and 540 ns. A clock-period parameter turns each width into a whole number of clock cycles, rounding up. The register also holds a sticky lock bit. Software can set the lock but cannot clear it. Once it is set, the whole register ignores writes until the next power-on or hard reset, which is the asynchronous reset of this block.

Top module: `strobe_wait_gen`

## Requirements
- R1: After reset, the selection register reads 0x00, both strobes are high, and wait and done are low.
- R2: The strobe stays low for exactly ceil(W / clock period) cycles, where W is 180 ns for code 0, 300 ns for code 1, 420 ns for code 2 and 540 ns for code 3. The code sits in register bits [1:0]. At 8 ns this gives 23, 38, 53 and 68 cycles.
- R3: wait_o is high in exactly those cycles in which a strobe is low.
- R4: done_o is high for one cycle, in the cycle right after the strobe rises. The block is idle after that cycle.
- R5: A start with dir_wr_i=1 drives only wr_n_o low, and a start with dir_wr_i=0 drives only rd_n_o low. The two strobes are never low together.
- R6: The width code is taken when the start is accepted. A register write during an access does not change that access's length.
- R7: While lock (register bit 7) is 1, writes to the register are ignored and the read value does not change.
- R8: Software cannot clear the lock. Only reset clears it.
- R9: Register bits [6:2] always read as zero, whatever value is written to them.
- R10: A start request is accepted only when the block is idle. A start during the strobe or during the done cycle is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low power-on / hard reset |
| cfg_we_i | input | 1 | Selection register write enable |
| cfg_wdata_i | input | 8 | Selection register write data |
| cfg_rdata_o | output | 8 | Selection register read value |
| start_i | input | 1 | Access start request, sampled while idle |
| dir_wr_i | input | 1 | Access direction: 1 = write, 0 = read |
| rd_n_o | output | 1 | Active-low read strobe |
| wr_n_o | output | 1 | Active-low write strobe |
| wait_o | output | 1 | Stretch request to the host interface |
| done_o | output | 1 | One-cycle access completion pulse |

## Verification
The assertions check on every cycle the behaviours that hold cycle by cycle:
- wait tracks the strobe (R3).
- The strobes are mutually exclusive and keep their direction through an access (R5).
- The one-cycle done pulse follows the strobe's rise (R4).
- The countdown cannot restart in mid-access (R10).
- The lock is sticky and a locked register does not change (R7, R8).

Only the bench's scenarios can show that:
- Each code gives its exact cycle count (R2).
- A write made in mid-access leaves that access's length alone (R6).
- Reserved bits read as zero (R9).
- Reset alone releases the lock (R8).

The bench covers these by comparing against a behavioural model on every clock and by measuring each strobe's width directly.

// File: rtl/strobe_pkg.sv
package strobe_pkg;

  typedef enum logic [1:0] {
    SEQ_IDLE   = 2'd0,
    SEQ_STROBE = 2'd1,
    SEQ_DONE   = 2'd2
  } seq_state_e;

  // Cycles needed to cover (base + step*code) ns at the given period, rounded up.
  function automatic int unsigned width_cycles(input int unsigned base_ns,
                                               input int unsigned step_ns,
                                               input int unsigned code,
                                               input int unsigned period_ps);
    int unsigned w_ps;
    w_ps = (base_ns + step_ns * code) * 1000;
    return (w_ps + period_ps - 1) / period_ps;
  endfunction

endpackage

// File: rtl/strobe_width_lut.sv
module strobe_width_lut
  import strobe_pkg::*;
#(
  parameter int unsigned BASE_NS       = 180,
  parameter int unsigned STEP_NS       = 120,
  parameter int unsigned CLK_PERIOD_PS = 8000,
  parameter int unsigned CODE_W        = 2,
  parameter int unsigned CNT_W         = 7
) (
  input  logic [CODE_W-1:0] code_i,
  output logic [CNT_W-1:0]  cycles_o
);

  localparam int unsigned N_CODES = 1 << CODE_W;

  logic [CNT_W-1:0] len_tbl [N_CODES];

  for (genvar g = 0; g < N_CODES; g++) begin : g_len
    localparam int unsigned RAW = width_cycles(BASE_NS, STEP_NS, g, CLK_PERIOD_PS);
    // a zero-length entry would collapse the strobe; floor at one cycle
    localparam int unsigned LEN = (RAW == 0) ? 1 : RAW;
    assign len_tbl[g] = CNT_W'(LEN);
  end

  assign cycles_o = len_tbl[code_i];

endmodule

// File: rtl/strobe_cfg_reg.sv
module strobe_cfg_reg #(
  parameter int unsigned CODE_W = 2,
  parameter int unsigned REG_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [REG_W-1:0]  wdata_i,
  output logic [REG_W-1:0]  rdata_o,
  output logic [CODE_W-1:0] code_o
);

  localparam int unsigned LOCK_BIT = REG_W - 1;
  localparam int unsigned RSVD_W   = REG_W - 1 - CODE_W;

  logic [CODE_W-1:0] code_q;
  logic              lock_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      code_q <= '0;
      lock_q <= 1'b0;
    end else if (we_i && !lock_q) begin
      code_q <= wdata_i[CODE_W-1:0];
      lock_q <= wdata_i[LOCK_BIT];
    end
  end

  assign code_o  = code_q;
  assign rdata_o = {lock_q, {RSVD_W{1'b0}}, code_q};

  assert_lock_sticky_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_q |=> lock_q);

  assert_locked_write_ignored_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lock_q && we_i) |=> $stable(rdata_o));

endmodule

// File: rtl/strobe_seq.sv
module strobe_seq
  import strobe_pkg::*;
#(
  parameter int unsigned CNT_W = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             dir_wr_i,
  input  logic [CNT_W-1:0] len_i,
  output logic             rd_n_o,
  output logic             wr_n_o,
  output logic             wait_o,
  output logic             done_o
);

  seq_state_e       state_q;
  logic [CNT_W-1:0] cnt_q;
  logic             dir_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= SEQ_IDLE;
      cnt_q   <= '0;
      dir_q   <= 1'b0;
    end else begin
      unique case (state_q)
        SEQ_IDLE: if (start_i) begin
          state_q <= SEQ_STROBE;
          dir_q   <= dir_wr_i;
          cnt_q   <= (len_i == '0) ? '0 : len_i - CNT_W'(1);
        end
        SEQ_STROBE: begin
          if (cnt_q == '0) state_q <= SEQ_DONE;
          else             cnt_q   <= cnt_q - CNT_W'(1);
        end
        SEQ_DONE: state_q <= SEQ_IDLE;
        default:  state_q <= SEQ_IDLE;
      endcase
    end
  end

  assign rd_n_o = !((state_q == SEQ_STROBE) && !dir_q);
  assign wr_n_o = !((state_q == SEQ_STROBE) &&  dir_q);
  assign wait_o = (state_q == SEQ_STROBE);
  assign done_o = (state_q == SEQ_DONE);

  assert_wait_tracks_strobe_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wait_o == (!rd_n_o || !wr_n_o));

  assert_one_strobe_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!rd_n_o && !wr_n_o));

  assert_dir_held_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wait_o && cnt_q != '0) |=> ($stable(rd_n_o) && $stable(wr_n_o)));

  assert_done_after_strobe_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wait_o && cnt_q == '0) |=> (done_o && rd_n_o && wr_n_o));

  assert_done_single_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> (!done_o && !wait_o));

  assert_no_restart_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wait_o && cnt_q != '0) |=> (wait_o && cnt_q == $past(cnt_q) - CNT_W'(1)));

endmodule

// File: rtl/strobe_wait_gen.sv
module strobe_wait_gen
  import strobe_pkg::*;
#(
  parameter int unsigned BASE_NS       = 180,
  parameter int unsigned STEP_NS       = 120,
  parameter int unsigned CLK_PERIOD_PS = 8000,
  parameter int unsigned CODE_W        = 2,
  parameter int unsigned REG_W         = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_we_i,
  input  logic [REG_W-1:0] cfg_wdata_i,
  output logic [REG_W-1:0] cfg_rdata_o,
  input  logic             start_i,
  input  logic             dir_wr_i,
  output logic             rd_n_o,
  output logic             wr_n_o,
  output logic             wait_o,
  output logic             done_o
);

  localparam int unsigned MAX_CODE = (1 << CODE_W) - 1;
  localparam int unsigned MAX_CYC  = width_cycles(BASE_NS, STEP_NS, MAX_CODE, CLK_PERIOD_PS);
  localparam int unsigned CNT_W    = $clog2(MAX_CYC + 2);

  logic [CODE_W-1:0] code;
  logic [CNT_W-1:0]  len;

  strobe_cfg_reg #(
    .CODE_W (CODE_W),
    .REG_W  (REG_W)
  ) u_cfg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (cfg_we_i),
    .wdata_i (cfg_wdata_i),
    .rdata_o (cfg_rdata_o),
    .code_o  (code)
  );

  strobe_width_lut #(
    .BASE_NS       (BASE_NS),
    .STEP_NS       (STEP_NS),
    .CLK_PERIOD_PS (CLK_PERIOD_PS),
    .CODE_W        (CODE_W),
    .CNT_W         (CNT_W)
  ) u_lut (
    .code_i   (code),
    .cycles_o (len)
  );

  strobe_seq #(
    .CNT_W (CNT_W)
  ) u_seq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start_i),
    .dir_wr_i (dir_wr_i),
    .len_i    (len),
    .rd_n_o   (rd_n_o),
    .wr_n_o   (wr_n_o),
    .wait_o   (wait_o),
    .done_o   (done_o)
  );

  // Reserved field must never read back set.
  assert_rsvd_zero_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_rdata_o[REG_W-2:CODE_W] == '0);

endmodule

// File: tb/strobe_wait_gen_test.sv
`timescale 1ns/1ps
module strobe_wait_gen_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_we = 1'b0;
  logic [7:0] cfg_wdata = 8'h00;
  logic [7:0] cfg_rdata;
  logic       start = 1'b0;
  logic       dir_wr = 1'b0;
  logic       rd_n, wr_n, wt, done;

  int vectors = 0;
  int fails = 0;
  int cyc = 0;

  always #4 clk = ~clk;

  strobe_wait_gen uut (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .cfg_we_i    (cfg_we),
    .cfg_wdata_i (cfg_wdata),
    .cfg_rdata_o (cfg_rdata),
    .start_i     (start),
    .dir_wr_i    (dir_wr),
    .rd_n_o      (rd_n),
    .wr_n_o      (wr_n),
    .wait_o      (wt),
    .done_o      (done)
  );

  // Expected cycles from the width table: ceil((180 + 120*code) ns / 8 ns).
  function automatic int exp_cycles(input int code);
    int ns;
    ns = 180 + 120 * code;
    return (ns * 1000 + 7999) / 8000;
  endfunction

  // Behavioural reference model.
  int       m_left;
  bit       m_done;
  bit       m_dir;
  int       m_code;
  bit       m_lock;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_left = 0; m_done = 0; m_dir = 0; m_code = 0; m_lock = 0;
    end else begin
      if (m_done) m_done = 0;
      else if (m_left > 0) begin
        m_left = m_left - 1;
        if (m_left == 0) m_done = 1;
      end else if (start) begin
        m_left = exp_cycles(m_code);
        m_dir  = dir_wr;
      end
      if (cfg_we && !m_lock) begin
        m_code = cfg_wdata[1:0];
        m_lock = cfg_wdata[7];
      end
    end
  end

  task automatic check(input string req, input string what, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Per-cycle comparison against the model.
  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      check("R5", "rd_n", rd_n, !(m_left > 0 && !m_dir));
      check("R5", "wr_n", wr_n, !(m_left > 0 && m_dir));
      check("R3", "wait", wt, m_left > 0);
      check("R4", "done", done, m_done);
      check("R7", "rdata", cfg_rdata, {m_lock, 5'b0, m_code[1:0]});
    end
    if (cyc > 50000) begin
      fails++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  task automatic write_cfg(input logic [7:0] v);
    @(negedge clk);
    cfg_we = 1'b1; cfg_wdata = v;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // Runs one access; mid_wr >= 0 writes that value three cycles into the strobe;
  // hold keeps start high during the strobe (R10).
  task automatic access(input bit wr, input int mid_wr, input bit hold, output int width);
    int guard;
    @(negedge clk);
    start = 1'b1; dir_wr = wr;
    @(negedge clk);
    start = hold;
    width = 0; guard = 0;
    while (!done && guard < 1000) begin
      if (!rd_n || !wr_n) width++;
      if (guard == 3 && mid_wr >= 0) begin cfg_we = 1'b1; cfg_wdata = mid_wr[7:0]; end
      else cfg_we = 1'b0;
      @(negedge clk);
      guard++;
    end
    start = 1'b0; cfg_we = 1'b0;
  endtask

  initial begin
    int w;
    repeat (3) @(negedge clk);
    check("R1", "reset rdata", cfg_rdata, 8'h00);
    check("R1", "reset strobes", {rd_n, wr_n}, 2'b11);
    check("R1", "reset wait/done", {wt, done}, 2'b00);
    rst_n = 1'b1;

    // R2 / R5: every code, both directions
    for (int c = 0; c < 4; c++) begin
      write_cfg(8'(c));
      access(1'b0, -1, 1'b0, w);
      check("R2", "read width", w, exp_cycles(c));
      access(1'b1, -1, 1'b0, w);
      check("R2", "write width", w, exp_cycles(c));
    end

    // R6: mid-access write does not alter current access
    write_cfg(8'h00);
    access(1'b0, 8'h03, 1'b0, w);
    check("R6", "width after mid write", w, 23);
    access(1'b1, -1, 1'b0, w);
    check("R6", "next access uses new code", w, 68);

    // R10: start held through strobe
    write_cfg(8'h01);
    access(1'b1, -1, 1'b1, w);
    check("R10", "held start width", w, 38);
    repeat (2) @(negedge clk);
    check("R10", "idle after held start", wt, 0);

    // R9: reserved bits
    write_cfg(8'h7E);
    check("R9", "reserved readback", cfg_rdata, 8'h02);

    // R7 / R8: lock
    write_cfg(8'h81);
    check("R7", "locked readback", cfg_rdata, 8'h81);
    write_cfg(8'h02);
    check("R8", "clear attempt", cfg_rdata, 8'h81);
    write_cfg(8'h03);
    check("R7", "code frozen", cfg_rdata, 8'h81);
    access(1'b0, -1, 1'b0, w);
    check("R7", "locked width", w, 38);

    // R8: reset clears lock
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check("R8", "lock after reset", cfg_rdata, 8'h00);
    rst_n = 1'b1;
    write_cfg(8'h02);
    check("R8", "writable after reset", cfg_rdata, 8'h02);
    access(1'b1, -1, 1'b0, w);
    check("R2", "code 2 after reset", w, 53);

    repeat (3) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule